// File: doc/BRIEF.md
# LED Controller Power-Mode Sequencer

This block steps a lighting controller through its power modes: reset, standby, internal startup, boost soft-start and normal operation. It watches an active-low external reset, a power-on-reset flag, a thermal-shutdown flag and a reference-ready flag. It also watches two register bits, standby-release and boost-enable. From these it drives a register-clear strobe, a bias/oscillator enable, a boost run enable, a low-current soft-start enable and a global LED enable.

Both timed phases count ticks of an internal prescaler. Each timer's prescaler restarts whenever its phase is entered or its wait condition is broken, so every delay lasts an exact number of clock cycles. With the defaults, one tick is 1 ms. The startup wait is then 10 ticks and the soft-start is 20 ticks.

States and transitions:
- RESET goes to STANDBY.
- STANDBY goes to STARTUP when standby-release is set.
- STARTUP goes to SOFTSTART or to NORMAL once its timer expires.
- SOFTSTART goes to NORMAL once its timer expires.
- NORMAL goes back to SOFTSTART on a rising edge of boost-enable.
- Over-temperature sends SOFTSTART or NORMAL back to STARTUP.
- Clearing standby-release sends any active state back to STANDBY.

Top module: `pmseq_top`

## Requirements
- R1: While `ext_rst_n` is low, `mode` is 0 (RESET) at once. When `por_flag` is high at a clock edge, `mode` is 0 after that edge. In RESET, `regs_clr` is 1 and all other enables are 0.
- R2: RESET moves to STANDBY (`mode` 1) at the first edge with both reset sources inactive. In STANDBY all enables are 0, whatever `boost_en` is.
- R3: From STANDBY, a high `stby_rel` gives STARTUP (`mode` 2) at the next edge. In STARTUP, `bias_en` is 1 and `led_en`, `boost_run` and `boost_soft` are 0.
- R4: The startup timer advances only while `ref_ok` is 1 and `thsd_flag` is 0; otherwise it restarts. STARTUP is left at the edge that follows STARTUP_TICKS*TICK_DIV qualified edges.
- R5: On leaving STARTUP, the next state is SOFTSTART (`mode` 3) if `boost_en` is 1, and NORMAL (`mode` 4) if it is 0.
- R6: In SOFTSTART, `bias_en`, `boost_run` and `boost_soft` are 1 and `led_en` is 0. The state lasts exactly SOFT_TICKS*TICK_DIV+1 cycles and then moves to NORMAL.
- R7: In NORMAL, `bias_en` and `led_en` are 1, `boost_soft` is 0, and `boost_run` follows `boost_en` in the same cycle.
- R8: A 0-to-1 change of `boost_en` seen in NORMAL gives SOFTSTART at the next edge. A `boost_en` that stays high causes no re-entry.
- R9: A high `thsd_flag` in SOFTSTART or NORMAL gives STARTUP at the next edge. STARTUP is held for as long as the flag stays high.
- R10: A low `stby_rel` in STARTUP, SOFTSTART or NORMAL gives STANDBY at the next edge, with all enables 0.
- R11: `mode` encodes the states as RESET=0, STANDBY=1, STARTUP=2, SOFTSTART=3, NORMAL=4. At most one of `regs_clr`, `boost_soft` and `led_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| por_flag | input | 1 | Power-on reset active |
| thsd_flag | input | 1 | Over-temperature flag |
| ref_ok | input | 1 | Reference voltage ready |
| stby_rel | input | 1 | Standby-release register bit |
| boost_en | input | 1 | Boost-enable register bit |
| regs_clr | output | 1 | Register-clear strobe, high in RESET |
| bias_en | output | 1 | Bias and oscillator enable |
| boost_run | output | 1 | Boost converter run enable |
| boost_soft | output | 1 | Low-current soft-start enable |
| led_en | output | 1 | Global LED output enable |
| mode | output | 3 | Encoded current state |

## Verification
Every state change takes effect one clock edge after the input that causes it. The exception is the external reset, which acts at once. The enables are decoded from the state, except `boost_run` in NORMAL, which follows `boost_en` in the same cycle. The startup timer expires 40 edges after its wait condition is first met, with the bench's four-cycle tick. Soft-start lasts 81 edges after it is entered. The bench drives inputs on falling edges and queues each expectation with a count of falling edges to wait. It checks one edge before and one edge at every expected transition, so an off-by-one in either timer is caught.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_STANDBY = 3'd1,
        PM_STARTUP = 3'd2,
        PM_SOFT    = 3'd3,
        PM_NORMAL  = 3'd4
    } pm_state_e;

    localparam int unsigned PM_NUM_TIMERS = 2;
    localparam int unsigned PM_TMR_START  = 0;
    localparam int unsigned PM_TMR_SOFT   = 1;

endpackage

// File: rtl/pmseq_timer.sv
module pmseq_timer #(
    parameter int unsigned TICK_DIV = 100000,
    parameter int unsigned TICKS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned CNT_W = $clog2(TICKS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(TICKS);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (cnt_q != CNT_END) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign done = (cnt_q == CNT_END);

endmodule

// File: rtl/pmseq_rise.sv
module pmseq_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;

endmodule

// File: rtl/pmseq_fsm.sv
module pmseq_fsm
    import pmseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por_flag,
    input  logic      stby_rel,
    input  logic      thsd_flag,
    input  logic      ref_ok,
    input  logic      boost_en,
    input  logic      boost_rise,
    input  logic      start_done,
    input  logic      soft_done,
    output pm_state_e state,
    output logic      start_run,
    output logic      soft_run,
    output logic      regs_clr,
    output logic      bias_en,
    output logic      boost_run,
    output logic      boost_soft,
    output logic      led_en
);
    pm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= PM_RESET;
        else if (por_flag) state_q <= PM_RESET;
        else               state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RESET: state_d = PM_STANDBY;
            PM_STANDBY: begin
                if (stby_rel) state_d = PM_STARTUP;
            end
            PM_STARTUP: begin
                if (!stby_rel)                    state_d = PM_STANDBY;
                else if (start_done && !thsd_flag) state_d = boost_en ? PM_SOFT : PM_NORMAL;
            end
            PM_SOFT: begin
                if (!stby_rel)      state_d = PM_STANDBY;
                else if (thsd_flag) state_d = PM_STARTUP;
                else if (soft_done) state_d = PM_NORMAL;
            end
            PM_NORMAL: begin
                if (!stby_rel)       state_d = PM_STANDBY;
                else if (thsd_flag)  state_d = PM_STARTUP;
                else if (boost_rise) state_d = PM_SOFT;
            end
            default: state_d = PM_RESET;
        endcase
    end

    always_comb begin
        regs_clr   = 1'b0;
        bias_en    = 1'b0;
        boost_run  = 1'b0;
        boost_soft = 1'b0;
        led_en     = 1'b0;
        start_run  = 1'b0;
        soft_run   = 1'b0;
        unique case (state_q)
            PM_RESET:   regs_clr = 1'b1;
            PM_STANDBY: ;
            PM_STARTUP: begin
                bias_en   = 1'b1;
                start_run = ref_ok & ~thsd_flag;
            end
            PM_SOFT: begin
                bias_en    = 1'b1;
                boost_run  = 1'b1;
                boost_soft = 1'b1;
                soft_run   = 1'b1;
            end
            PM_NORMAL: begin
                bias_en   = 1'b1;
                boost_run = boost_en;
                led_en    = 1'b1;
            end
            default: regs_clr = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pmseq_top.sv
module pmseq_top
    import pmseq_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 100000,
    parameter int unsigned STARTUP_TICKS = 10,
    parameter int unsigned SOFT_TICKS    = 20
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic       por_flag,
    input  logic       thsd_flag,
    input  logic       ref_ok,
    input  logic       stby_rel,
    input  logic       boost_en,
    output logic       regs_clr,
    output logic       bias_en,
    output logic       boost_run,
    output logic       boost_soft,
    output logic       led_en,
    output logic [2:0] mode
);
    pm_state_e state;
    logic      boost_rise;
    logic [PM_NUM_TIMERS-1:0] tmr_run;
    logic [PM_NUM_TIMERS-1:0] tmr_done;

    pmseq_rise u_rise (
        .clk   (clk),
        .rst_n (ext_rst_n),
        .din   (boost_en),
        .rise  (boost_rise)
    );

    for (genvar g = 0; g < PM_NUM_TIMERS; g++) begin : g_tmr
        localparam int unsigned LEN = (g == PM_TMR_START) ? STARTUP_TICKS : SOFT_TICKS;
        pmseq_timer #(
            .TICK_DIV (TICK_DIV),
            .TICKS    (LEN)
        ) u_tmr (
            .clk   (clk),
            .rst_n (ext_rst_n),
            .run   (tmr_run[g]),
            .done  (tmr_done[g])
        );
    end

    pmseq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (ext_rst_n),
        .por_flag   (por_flag),
        .stby_rel   (stby_rel),
        .thsd_flag  (thsd_flag),
        .ref_ok     (ref_ok),
        .boost_en   (boost_en),
        .boost_rise (boost_rise),
        .start_done (tmr_done[PM_TMR_START]),
        .soft_done  (tmr_done[PM_TMR_SOFT]),
        .state      (state),
        .start_run  (tmr_run[PM_TMR_START]),
        .soft_run   (tmr_run[PM_TMR_SOFT]),
        .regs_clr   (regs_clr),
        .bias_en    (bias_en),
        .boost_run  (boost_run),
        .boost_soft (boost_soft),
        .led_en     (led_en)
    );

    assign mode = state;

endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
    parameter int unsigned TICK_DIV   = 100000,
    parameter int unsigned SOFT_TICKS = 20
) (
    input logic       clk,
    input logic       ext_rst_n,
    input logic       por_flag,
    input logic       thsd_flag,
    input logic       stby_rel,
    input logic       boost_en,
    input logic       regs_clr,
    input logic       boost_run,
    input logic       boost_soft,
    input logic       led_en,
    input logic [2:0] mode
);
    localparam int unsigned SOFT_MAX = SOFT_TICKS * TICK_DIV + 1;

    int unsigned soft_cyc;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)       soft_cyc <= 0;
        else if (mode == 3'd3) soft_cyc <= soft_cyc + 1;
        else                   soft_cyc <= 0;
    end

    p_por_reset_r1: assert property (@(posedge clk) disable iff (!ext_rst_n)
        por_flag |=> (mode == 3'd0) && regs_clr);

    p_soft_outputs_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (mode == 3'd3) |-> (!led_en && boost_soft && boost_run));

    p_soft_length_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (mode == 3'd3) |-> (soft_cyc < SOFT_MAX));

    p_boost_edge_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
        ((mode == 3'd4) && boost_en && !$past(boost_en) && stby_rel && !thsd_flag && !por_flag)
        |=> (mode == 3'd3));

    p_thermal_r9: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (((mode == 3'd3) || (mode == 3'd4)) && thsd_flag && stby_rel && !por_flag)
        |=> (mode == 3'd2));

    p_standby_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (!por_flag && !stby_rel) |=> (mode == 3'd1) && !led_en && !boost_run);

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $onehot0({regs_clr, boost_soft, led_en}));

    p_mode_range_r11: assert property (@(posedge clk) disable iff (!ext_rst_n)
        mode <= 3'd4);

endmodule

bind pmseq_top pmseq_chk #(
    .TICK_DIV   (TICK_DIV),
    .SOFT_TICKS (SOFT_TICKS)
) u_chk (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .por_flag   (por_flag),
    .thsd_flag  (thsd_flag),
    .stby_rel   (stby_rel),
    .boost_en   (boost_en),
    .regs_clr   (regs_clr),
    .boost_run  (boost_run),
    .boost_soft (boost_soft),
    .led_en     (led_en),
    .mode       (mode)
);

// File: tb/tb_pmseq_top.sv
module tb_pmseq_top;
    localparam int unsigned DIV = 4;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic por_flag = 1'b0;
    logic thsd_flag = 1'b0;
    logic ref_ok = 1'b1;
    logic stby_rel = 1'b0;
    logic boost_en = 1'b0;
    logic regs_clr, bias_en, boost_run, boost_soft, led_en;
    logic [2:0] mode;

    always #5 clk = ~clk;

    pmseq_top #(
        .TICK_DIV      (DIV),
        .STARTUP_TICKS (10),
        .SOFT_TICKS    (20)
    ) dut (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .por_flag   (por_flag),
        .thsd_flag  (thsd_flag),
        .ref_ok     (ref_ok),
        .stby_rel   (stby_rel),
        .boost_en   (boost_en),
        .regs_clr   (regs_clr),
        .bias_en    (bias_en),
        .boost_run  (boost_run),
        .boost_soft (boost_soft),
        .led_en     (led_en),
        .mode       (mode)
    );

    // outputs packed as {regs_clr, bias_en, boost_run, boost_soft, led_en}
    localparam logic [4:0] O_RST  = 5'b10000;
    localparam logic [4:0] O_OFF  = 5'b00000;
    localparam logic [4:0] O_UP   = 5'b01000;
    localparam logic [4:0] O_SOFT = 5'b01110;
    localparam logic [4:0] O_NRM0 = 5'b01001;
    localparam logic [4:0] O_NRM1 = 5'b01101;

    typedef struct {
        int         dly;
        logic [2:0] m;
        logic [4:0] o;
        string      tag;
    } exp_t;

    exp_t q[$];
    bit   busy = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    task automatic expect_at(input int dly, input logic [2:0] m, input logic [4:0] o, input string tag);
        exp_t e;
        e.dly = dly; e.m = m; e.o = o; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic drain();
        wait (q.size() == 0 && !busy);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            wait (q.size() != 0);
            busy = 1'b1;
            e = q.pop_front();
            repeat (e.dly) @(negedge clk);
            checks++;
            if (mode !== e.m || {regs_clr, bias_en, boost_run, boost_soft, led_en} !== e.o) begin
                errors++;
                $display("FAIL %s: mode=%0d outs=%b expected mode=%0d outs=%b",
                         e.tag, mode, {regs_clr, bias_en, boost_run, boost_soft, led_en}, e.m, e.o);
            end
            busy = 1'b0;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        // R1: external reset held low
        expect_at(2, 3'd0, O_RST, "R1 ext reset");
        drain();
        // R2: release to standby
        @(negedge clk); ext_rst_n = 1'b1;
        expect_at(1, 3'd1, O_OFF, "R2 standby after reset");
        drain();
        // R2: boost_en has no effect in standby
        @(negedge clk); boost_en = 1'b1;
        expect_at(3, 3'd1, O_OFF, "R2 standby ignores boost_en");
        drain();
        // R3: startup entry, reference not ready
        @(negedge clk); boost_en = 1'b0; ref_ok = 1'b0; stby_rel = 1'b1;
        expect_at(1, 3'd2, O_UP, "R3 startup entry");
        expect_at(60, 3'd2, O_UP, "R4 wait for ref_ok");
        drain();
        // R4/R5: timer expiry to normal
        @(negedge clk); ref_ok = 1'b1;
        expect_at(40, 3'd2, O_UP, "R4 startup one edge before expiry");
        expect_at(1, 3'd4, O_NRM0, "R5 normal with boost off");
        drain();
        // R8/R6: rising edge re-enters soft-start
        @(negedge clk); boost_en = 1'b1;
        expect_at(1, 3'd3, O_SOFT, "R8 rise enters soft-start");
        expect_at(80, 3'd3, O_SOFT, "R6 soft-start last cycle");
        expect_at(1, 3'd4, O_NRM1, "R6 soft-start ends in normal");
        expect_at(5, 3'd4, O_NRM1, "R8 steady high no re-entry");
        drain();
        // R7: boost_run follows boost_en in normal
        @(negedge clk); boost_en = 1'b0;
        expect_at(0, 3'd4, O_NRM0, "R7 boost_run follows boost_en");
        drain();
        @(negedge clk); boost_en = 1'b1;
        expect_at(1, 3'd3, O_SOFT, "R8 second rise");
        drain();
        // R9: over-temperature from soft-start
        @(negedge clk); thsd_flag = 1'b1;
        expect_at(1, 3'd2, O_UP, "R9 thermal to startup");
        expect_at(50, 3'd2, O_UP, "R9 held while hot");
        drain();
        // R5: with boost_en high, startup leads to soft-start
        @(negedge clk); thsd_flag = 1'b0;
        expect_at(40, 3'd2, O_UP, "R4 restart after thermal");
        expect_at(1, 3'd3, O_SOFT, "R5 soft-start with boost on");
        drain();
        // R10: clearing standby-release
        @(negedge clk); stby_rel = 1'b0;
        expect_at(1, 3'd1, O_OFF, "R10 back to standby");
        drain();
        // R1: power-on reset from startup
        @(negedge clk); stby_rel = 1'b1;
        expect_at(1, 3'd2, O_UP, "R3 startup again");
        drain();
        @(negedge clk); por_flag = 1'b1;
        expect_at(1, 3'd0, O_RST, "R1 por reset");
        drain();
        @(negedge clk); por_flag = 1'b0;
        expect_at(1, 3'd1, O_OFF, "R2 standby after por");
        expect_at(1, 3'd2, O_UP, "R3 startup after standby");
        drain();
        // R10 from normal and R11 code of normal
        @(negedge clk); boost_en = 1'b0;
        expect_at(41, 3'd4, O_NRM0, "R11 normal code 4");
        drain();
        @(negedge clk); stby_rel = 1'b0;
        expect_at(1, 3'd1, O_OFF, "R10 normal to standby");
        drain();
        // R1: asynchronous external reset
        #2 ext_rst_n = 1'b0;
        #1;
        checks++;
        if (mode !== 3'd0 || regs_clr !== 1'b1) begin
            errors++;
            $display("FAIL R1 async reset: mode=%0d clr=%b expected mode=0 clr=1", mode, regs_clr);
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule